// File: doc/BRIEF.md
# Programmable CRC Engine with Bit Reflection

This block is a 32-bit CRC engine that sits on a simple register bus. Software loads a seed and a generator polynomial, then writes a control word that reloads the running CRC from the seed and selects how the input and output bits are reflected. Each write to the data register folds its bits into the running CRC in a single clock. A word write folds 32 bits and a byte write folds 8 bits, and the two kinds of write can be mixed freely within one stream. Reading the data register returns the running CRC, bit-reversed as a whole if output reflection is on.

The engine always shifts MSB-first in the non-reflected domain. The reflected CRC-32 and CRC-32C algorithms are obtained by loading the non-reflected polynomial, enabling input reflection and enabling output reflection. Because input reflection can be changed mid-stream without touching the running value, a buffer can start with bytes up to a word boundary, go on with whole words, and end with a byte tail.

Top module: `crc_periph`

## Requirements
- R1: After a hardware reset the seed register (offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7, the control register (offset 0x08) reads 0, and the data register (offset 0x00) reads 0xFFFFFFFF.
- R2: A word write to control with bit 0 set loads the running CRC from the seed register on that clock. Bit 0 always reads back as 0, and bits [7:5] keep their written values.
- R3: A byte write to offset 0x00 takes wdata_i[7:0] only and advances the CRC by 8 bits, MSB-first: for each bit d, fb = crc[31]^d, crc = (crc<<1) ^ (fb ? poly : 0).
- R4: A word write to offset 0x00 advances the CRC by all 32 bits of the (possibly reflected) word, bit 31 first. If both strobes are high, the word write wins.
- R5: Control bits [6:5] select the reflection of a word input: 2'b00 none, 2'b01 bits reversed within each byte, 2'b10 bits reversed within each 16-bit half, 2'b11 bits reversed across the whole 32-bit word.
- R6: For a byte write, any nonzero value of control bits [6:5] reverses the 8 data bits; 2'b00 leaves them unchanged.
- R7: With control bit 7 set, a read of offset 0x00 returns the running CRC reversed across all 32 bits; with bit 7 clear it is returned unchanged.
- R8: A control write with bit 0 clear changes the reflection settings but leaves the running CRC unchanged.
- R9: Writes to offsets other than 0x00, 0x08, 0x10 and 0x14, and byte writes to any offset other than 0x00, change no register. Reads of undefined offsets return 0.
- R10: With seed 0xFFFFFFFF, input mode 2'b01 for bytes or 2'b11 for words, and output reflection on, the ASCII string "123456789" gives a read value whose complement is 0xCBF43926 for polynomial 0x04C11DB7 and 0xE3069283 for polynomial 0x1EDC6F41. This holds for a stream of bytes only and for a stream of words followed by bytes.
- R11: A read of the data register right after a reset-bit write returns the seed, reversed if output reflection is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Byte address of the register accessed |
| wdata_i | input | 32 | Write data |
| wr_word_i | input | 1 | 32-bit write strobe |
| wr_byte_i | input | 1 | 8-bit write strobe (lane 0) |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The assertions assume that a strobe is held for exactly one clock per access, and that the address is stable while the strobe is high. The bench drives every access from the falling edge and drops the strobes right after the next rising edge. The assertions also treat a simultaneous byte and word strobe as a word write. The bench raises only one strobe at a time, so that priority is covered by the requirement and not by stimulus. Read data is sampled combinationally one falling edge after the write that changed it.

// File: rtl/crc_periph_pkg.sv
package crc_periph_pkg;
  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_SEED = 'h10;
  localparam int unsigned OFS_POLY = 'h14;

  localparam int unsigned CTRL_RELOAD_BIT = 0;
  localparam int unsigned CTRL_IN_LSB     = 5;
  localparam int unsigned CTRL_OUT_BIT    = 7;

  typedef enum logic [1:0] {
    REFL_NONE = 2'b00,
    REFL_BYTE = 2'b01,
    REFL_HALF = 2'b10,
    REFL_WORD = 2'b11
  } refl_mode_e;

  typedef struct packed {
    logic       out_refl;
    refl_mode_e in_refl;
  } ctrl_t;
endpackage

// File: rtl/crc_bit_rev.sv
module crc_bit_rev #(
  parameter int unsigned W   = 32,
  parameter int unsigned GRP = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int unsigned NG = W / GRP;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar b = 0; b < GRP; b++) begin : g_bit
      assign d_o[g*GRP + b] = d_i[g*GRP + GRP - 1 - b];
    end
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
  parameter int unsigned W     = 32,
  parameter int unsigned NBITS = 32
) (
  input  logic [W-1:0]     crc_i,
  input  logic [W-1:0]     poly_i,
  input  logic [NBITS-1:0] data_i,
  output logic [W-1:0]     crc_o
);
  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_i;
    for (int i = NBITS - 1; i >= 0; i--) begin
      fb = c[W-1] ^ data_i[i];
      c  = {c[W-2:0], 1'b0} ^ (fb ? poly_i : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/crc_in_stage.sv
module crc_in_stage
  import crc_periph_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 8
) (
  input  refl_mode_e    mode_i,
  input  logic [W-1:0]  word_i,
  output logic [W-1:0]  word_o,
  output logic [BW-1:0] byte_o
);
  localparam int unsigned NV = 3; // byte, half, full-word groups

  logic [W-1:0]  rev_w [NV];
  logic [BW-1:0] rev_b;

  for (genvar k = 0; k < NV; k++) begin : g_rev
    crc_bit_rev #(.W(W), .GRP(BW << k)) i_rev (
      .d_i(word_i),
      .d_o(rev_w[k])
    );
  end

  crc_bit_rev #(.W(BW), .GRP(BW)) i_rev_byte (
    .d_i(word_i[BW-1:0]),
    .d_o(rev_b)
  );

  always_comb begin
    unique case (mode_i)
      REFL_BYTE: word_o = rev_w[0];
      REFL_HALF: word_o = rev_w[1];
      REFL_WORD: word_o = rev_w[2];
      default:   word_o = word_i;
    endcase
    byte_o = (mode_i == REFL_NONE) ? word_i[BW-1:0] : rev_b;
  end
endmodule

// File: rtl/crc_periph.sv
module crc_periph
  import crc_periph_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter int unsigned DW       = 32,
  parameter int unsigned BW       = 8,
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_word_i,
  input  logic          wr_byte_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] seed_q, poly_q, crc_q;
  ctrl_t         ctrl_q;

  logic sel_data, sel_ctrl, sel_seed, sel_poly;
  assign sel_data = (addr_i == AW'(OFS_DATA));
  assign sel_ctrl = (addr_i == AW'(OFS_CTRL));
  assign sel_seed = (addr_i == AW'(OFS_SEED));
  assign sel_poly = (addr_i == AW'(OFS_POLY));

  logic push_word, push_byte, wr_ctrl, wr_seed, wr_poly, reload;
  assign push_word = wr_word_i & sel_data;
  assign push_byte = wr_byte_i & ~wr_word_i & sel_data;
  assign wr_ctrl   = wr_word_i & sel_ctrl;
  assign wr_seed   = wr_word_i & sel_seed;
  assign wr_poly   = wr_word_i & sel_poly;
  assign reload    = wr_ctrl & wdata_i[CTRL_RELOAD_BIT];

  logic [DW-1:0] in_word;
  logic [BW-1:0] in_byte;

  crc_in_stage #(.W(DW), .BW(BW)) i_in_stage (
    .mode_i (ctrl_q.in_refl),
    .word_i (wdata_i),
    .word_o (in_word),
    .byte_o (in_byte)
  );

  logic [DW-1:0] crc_after_word, crc_after_byte;

  crc_fold #(.W(DW), .NBITS(DW)) i_fold_word (
    .crc_i  (crc_q),
    .poly_i (poly_q),
    .data_i (in_word),
    .crc_o  (crc_after_word)
  );

  crc_fold #(.W(DW), .NBITS(BW)) i_fold_byte (
    .crc_i  (crc_q),
    .poly_i (poly_q),
    .data_i (in_byte),
    .crc_o  (crc_after_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= SEED_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
      crc_q  <= SEED_RST;
    end else begin
      if (wr_seed) seed_q <= wdata_i;
      if (wr_poly) poly_q <= wdata_i;
      if (wr_ctrl) begin
        ctrl_q.out_refl <= wdata_i[CTRL_OUT_BIT];
        ctrl_q.in_refl  <= refl_mode_e'(wdata_i[CTRL_IN_LSB +: 2]);
      end
      if (reload)         crc_q <= seed_q;
      else if (push_word) crc_q <= crc_after_word;
      else if (push_byte) crc_q <= crc_after_byte;
    end
  end

  logic [DW-1:0] crc_rev;

  crc_bit_rev #(.W(DW), .GRP(DW)) i_out_rev (
    .d_i(crc_q),
    .d_o(crc_rev)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_data)      rdata_o = ctrl_q.out_refl ? crc_rev : crc_q;
    else if (sel_ctrl) begin
      rdata_o[CTRL_OUT_BIT]        = ctrl_q.out_refl;
      rdata_o[CTRL_IN_LSB +: 2]    = ctrl_q.in_refl;
    end
    else if (sel_seed) rdata_o = seed_q;
    else if (sel_poly) rdata_o = poly_q;
  end
endmodule

// File: rtl/crc_periph_chk.sv
module crc_periph_chk
  import crc_periph_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          wr_word_i,
  input logic          wr_byte_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] crc_q,
  input logic [DW-1:0] seed_q,
  input logic [DW-1:0] poly_q
);
  logic is_data, is_ctrl, is_known, any_wr;
  assign is_data  = addr_i == AW'(OFS_DATA);
  assign is_ctrl  = addr_i == AW'(OFS_CTRL);
  assign is_known = is_data | is_ctrl | (addr_i == AW'(OFS_SEED)) | (addr_i == AW'(OFS_POLY));
  assign any_wr   = wr_word_i | wr_byte_i;

  // R2
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word_i && is_ctrl && wdata_i[0]) |=> (crc_q == $past(seed_q)));

  // R8
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word_i && is_ctrl && !wdata_i[0]) |=> $stable(crc_q));

  // R9
  undef_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((any_wr && !is_known) || (wr_byte_i && !wr_word_i && !is_data))
      |=> ($stable(crc_q) && $stable(seed_q) && $stable(poly_q)));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(any_wr && (is_data || is_ctrl)) |=> $stable(crc_q));

  // R2
  ctrl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ctrl |-> (rdata_o[0] == 1'b0));
endmodule

bind crc_periph crc_periph_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_word_i (wr_word_i),
  .wr_byte_i (wr_byte_i),
  .rdata_o   (rdata_o),
  .crc_q     (crc_q),
  .seed_q    (seed_q),
  .poly_q    (poly_q)
);

// File: tb/test_crc_periph.sv
`timescale 1ns/1ps
module test_crc_periph;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_word_i = 1'b0;
  logic        wr_byte_i = 1'b0;
  logic [31:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  crc_periph i_crc_periph (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_word_i(wr_word_i), .wr_byte_i(wr_byte_i), .rdata_o(rdata_o)
  );

  localparam logic [4:0] A_DATA = 5'h00, A_CTRL = 5'h08, A_SEED = 5'h10, A_POLY = 5'h14;

  function automatic logic [31:0] m_fold(logic [31:0] c, logic [31:0] p, logic [31:0] d, int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_rev(logic [31:0] x, int g);
    logic [31:0] y;
    for (int i = 0; i < 32; i++) y[(i / g) * g + g - 1 - (i % g)] = x[i];
    return y;
  endfunction

  function automatic logic [31:0] m_in_word(logic [31:0] x, int mode);
    case (mode)
      1: return m_rev(x, 8);
      2: return m_rev(x, 16);
      3: return m_rev(x, 32);
      default: return x;
    endcase
  endfunction

  function automatic logic [7:0] m_in_byte(logic [7:0] b, int mode);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7 - i] = b[i];
    return (mode == 0) ? b : r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr_w(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_word_i = 1'b1;
    @(posedge clk_i); #0.5;
    wr_word_i = 1'b0;
  endtask

  task automatic wr_b(logic [4:0] a, logic [7:0] b);
    @(negedge clk_i);
    addr_i = a; wdata_i = {24'hA5C35A, b}; wr_byte_i = 1'b1;
    @(posedge clk_i); #0.5;
    wr_byte_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a;
    #0.5 v = rdata_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got %08h expected %08h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, m, seed, w, lcg;
    string msg;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset values
    rd(A_SEED, v); chk("R1 seed", v, 32'hFFFF_FFFF);
    rd(A_POLY, v); chk("R1 poly", v, 32'h04C1_1DB7);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_DATA, v); chk("R1 data", v, 32'hFFFF_FFFF);
    // R9 undefined reads
    rd(5'h04, v); chk("R9 rd 04", v, 0);
    rd(5'h0C, v); chk("R9 rd 0C", v, 0);
    rd(5'h18, v); chk("R9 rd 18", v, 0);

    // R2 / R11 reload, self-clearing bit, out reflect
    wr_w(A_SEED, 32'h1234_5678);
    wr_w(A_CTRL, 32'hE1);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'hE0);
    rd(A_DATA, v); chk("R11 seed reflected", v, m_rev(32'h1234_5678, 32));
    wr_w(A_CTRL, 32'h01);
    rd(A_DATA, v); chk("R11 seed plain", v, 32'h1234_5678);
    rd(A_CTRL, v); chk("R2 ctrl zero", v, 32'h0);

    // R10 CRC-32 byte stream
    wr_w(A_SEED, 32'hFFFF_FFFF);
    wr_w(A_CTRL, 32'hA1);
    for (int i = 0; i < 9; i++) wr_b(A_DATA, 8'h31 + 8'(i));
    rd(A_DATA, v); chk("R10 crc32 bytes", ~v, 32'hCBF4_3926);
    // R10 / R8 mixed words then byte
    wr_w(A_CTRL, 32'hE1);
    wr_w(A_DATA, 32'h3433_3231);
    wr_w(A_DATA, 32'h3837_3635);
    wr_w(A_CTRL, 32'hA0);
    wr_b(A_DATA, 8'h39);
    rd(A_DATA, v); chk("R10 R8 crc32 mixed", ~v, 32'hCBF4_3926);
    // R10 Castagnoli
    wr_w(A_POLY, 32'h1EDC_6F41);
    wr_w(A_CTRL, 32'hA1);
    for (int i = 0; i < 9; i++) wr_b(A_DATA, 8'h31 + 8'(i));
    rd(A_DATA, v); chk("R10 crc32c bytes", ~v, 32'hE306_9283);

    // R8 ctrl rewrite keeps crc
    rd(A_DATA, m);
    wr_w(A_CTRL, 32'h20);
    rd(A_DATA, v); chk("R8 keep", v, m_rev(m, 32));

    // R4 R5 R7 word sweep
    lcg = 32'h1357_9BDF;
    wr_w(A_POLY, 32'h04C1_1DB7);
    for (int mode = 0; mode < 4; mode++) begin
      seed = lcg ^ 32'h0F0F_0000;
      wr_w(A_SEED, seed);
      wr_w(A_CTRL, 32'(mode << 5) | 32'h1);
      m = seed;
      for (int k = 0; k < 48; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        w = lcg;
        if (k == 10) wr_w(A_CTRL, 32'(mode << 5) | 32'h80);
        if (k == 30) wr_w(A_CTRL, 32'(mode << 5));
        wr_w(A_DATA, w);
        m = m_fold(m, 32'h04C1_1DB7, m_in_word(w, mode), 32);
        rd(A_DATA, v);
        msg = $sformatf("R4 R5 R7 word mode %0d k %0d", mode, k);
        chk(msg, v, (k >= 10 && k < 30) ? m_rev(m, 32) : m);
      end
    end

    // R3 R6 byte sweep
    wr_w(A_POLY, 32'h1EDC_6F41);
    wr_w(A_SEED, 32'hC001_D00D);
    for (int mode = 0; mode < 4; mode++) begin
      for (int b = 0; b < 256; b++) begin
        wr_w(A_CTRL, 32'(mode << 5) | 32'h1);
        wr_b(A_DATA, 8'(b));
        m = m_fold(32'hC001_D00D, 32'h1EDC_6F41, {24'h0, m_in_byte(8'(b), mode)}, 8);
        rd(A_DATA, v);
        msg = $sformatf("R3 R6 byte mode %0d val %02h", mode, b);
        chk(msg, v, m);
      end
    end

    // R9 ignored writes
    rd(A_DATA, m);
    wr_w(5'h04, 32'hDEAD_BEEF);
    wr_w(5'h0C, 32'hDEAD_BEEF);
    wr_w(5'h18, 32'hDEAD_BEEF);
    wr_b(A_SEED, 8'h55);
    wr_b(A_POLY, 8'h55);
    wr_b(A_CTRL, 8'hFF);
    rd(A_DATA, v); chk("R9 data kept", v, m);
    rd(A_SEED, v); chk("R9 seed kept", v, 32'hC001_D00D);
    rd(A_POLY, v); chk("R9 poly kept", v, 32'h1EDC_6F41);
    rd(A_CTRL, v); chk("R9 ctrl kept", v, 32'h60);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule